// File: doc/BRIEF.md
# Debug Instruction and Data Transfer Chains

This block holds the two scan chains an external debugger uses while a core is halted. The instruction chain accepts an opcode for the core and reports whether the previously issued opcode has finished. The data chain moves 32-bit words in both directions through two single-word mailboxes. The debugger polls by scanning the same chain again until the captured status bit reads 1.

The TAP controller and chain selector sit outside the block. They deliver one-cycle capture, shift, update and Run-Test/Idle-entry strobes, all synchronous to `clk`, and also provide the chain selects and the transfer direction. An opcode is issued when the TAP enters Run-Test/Idle. The block issues it only if the instruction chain was updated first, or if the data chain is selected. Selecting the data chain therefore lets one loaded opcode move a whole burst of words. On the core side there is a valid/accept handshake for opcodes, a completion pulse, and read and write strobes for the two mailboxes.

The issue controller is a three-state machine:
- IDLE: the previous opcode is complete.
- ISSUE: the opcode is offered to the core.
- EXEC: the core has accepted the opcode and has not yet finished it.

Its transitions are:
- START: IDLE to ISSUE on a valid issue request.
- ACCEPT: ISSUE to EXEC on `op_accept`.
- COMPLETE: EXEC to IDLE on `op_done`.

Top module: `dbg_xfer_chains`

## Requirements
- R1: After reset `op_valid`, `wdtr_full` and `rdtr_full` are 0, and the first instruction-chain capture reports completion bit 1.
- R2: The instruction chain is 33 bits, shifted LSB first. Bits 0..31 carry the opcode in, and bit 32 carries the completion flag out (1 only when the controller is in IDLE).
- R3: An instruction-chain update followed by Run-Test/Idle entry raises `op_valid` one cycle after the entry strobe, with `op_data` equal to the scanned opcode.
- R4: Ending an instruction-chain scan without Run-Test/Idle entry loads the opcode but does not issue it. A later Run-Test/Idle entry with the data chain selected issues it.
- R5: The completion bit captures 0 from issue until the `op_done` pulse, and 1 afterwards.
- R6: `op_valid` and `op_data` stay stable until `op_accept`. An instruction-chain update while not in IDLE leaves the loaded opcode unchanged.
- R7: The data chain is 34 bits, shifted LSB first: bits 0..31 data, bit 32 ready, bit 33 retry. Retry always captures 0.
- R8: Under EXTEST (`dir_ext`=1), capture returns zero data and ready = NOT `wdtr_full`. If ready was 1, the update stores the word, sets `wdtr_full` and shows the word on `wdtr_data`. A `wdtr_rd` pulse clears `wdtr_full`.
- R9: An EXTEST scan whose capture saw the outbound mailbox full reports ready 0, and its word is ignored (`wdtr_data` unchanged).
- R10: Under INTEST (`dir_ext`=0), capture returns the inbound word with ready 1 and clears `rdtr_full`. An empty mailbox gives zero data and ready 0.
- R11: A core write (`rdtr_wr`) to a full inbound mailbox is ignored.
- R12: With the data chain selected, every Run-Test/Idle entry in IDLE re-issues the last loaded opcode.
- R13: Issue requests that arrive while not in IDLE are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tdi | input | 1 | Serial scan input |
| capture_en | input | 1 | Capture-DR strobe |
| shift_en | input | 1 | Shift-DR strobe, one bit per cycle |
| update_en | input | 1 | Update-DR strobe |
| idle_enter | input | 1 | Strobe on entry to Run-Test/Idle |
| sel_itr | input | 1 | Instruction chain selected |
| sel_dtr | input | 1 | Data chain selected with INTEST or EXTEST active |
| dir_ext | input | 1 | 1 = EXTEST (toward core), 0 = INTEST |
| tdo | output | 1 | Serial scan output |
| op_valid | output | 1 | Opcode offered to core |
| op_data | output | DW | Opcode |
| op_accept | input | 1 | Core takes opcode |
| op_done | input | 1 | Core finished the opcode (pulse) |
| wdtr_data | output | DW | Outbound word |
| wdtr_full | output | 1 | Outbound mailbox holds a word |
| wdtr_rd | input | 1 | Core consumes outbound word |
| rdtr_wr | input | 1 | Core writes inbound word |
| rdtr_wdata | input | DW | Inbound word |
| rdtr_full | output | 1 | Inbound mailbox holds a word |

## Verification
Every strobe is sampled on the rising edge:
- A captured bit appears on `tdo` right after the capture edge.
- `op_valid` and `op_data` follow one edge after the Run-Test/Idle strobe.
- Mailbox flags and `wdtr_data` change on the edge that samples update, capture or a core strobe.

The bench drives on the falling edge and reads results at the next falling edge after the responsible rising edge, so each check falls exactly one register stage after its stimulus.

// File: rtl/dbg_xfer_pkg.sv
package dbg_xfer_pkg;
    localparam int DEF_DW = 32;

    typedef enum logic [1:0] {
        ITR_IDLE  = 2'd0,
        ITR_ISSUE = 2'd1,
        ITR_EXEC  = 2'd2
    } itr_state_t;
endpackage

// File: rtl/dbg_mbox.sv
module dbg_mbox #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          put,
    input  logic [DW-1:0] put_data,
    input  logic          take,
    output logic          full,
    output logic [DW-1:0] q
);
    // A put into a full mailbox is dropped; take only acts when full.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full <= 1'b0;
            q    <= '0;
        end else if (put && !full) begin
            full <= 1'b1;
            q    <= put_data;
        end else if (take && full) begin
            full <= 1'b0;
        end
    end
endmodule

// File: rtl/dbg_itr_chain.sv
module dbg_itr_chain
    import dbg_xfer_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          reissue_sel,
    input  logic          tdi,
    input  logic          capture_en,
    input  logic          shift_en,
    input  logic          update_en,
    input  logic          idle_enter,
    output logic          tdo_bit,
    output logic          op_valid,
    output logic [DW-1:0] op_data,
    input  logic          op_accept,
    input  logic          op_done
);
    localparam int LEN = DW + 1;

    itr_state_t     st, st_nx;
    logic [LEN-1:0] sr;
    logic [DW-1:0]  opc;
    logic           armed;
    logic           inst_done;
    logic           issue_req;

    assign issue_req = idle_enter && ((sel && armed) || reissue_sel);

    // next-state logic: START, ACCEPT, COMPLETE
    always_comb begin
        st_nx = st;
        unique case (st)
            ITR_IDLE:  if (issue_req) st_nx = ITR_ISSUE;
            ITR_ISSUE: if (op_accept) st_nx = ITR_EXEC;
            ITR_EXEC:  if (op_done)   st_nx = ITR_IDLE;
            default:   st_nx = ITR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ITR_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        op_valid  = 1'b0;
        inst_done = 1'b0;
        unique case (st)
            ITR_IDLE:  inst_done = 1'b1;
            ITR_ISSUE: op_valid  = 1'b1;
            default:   ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr    <= '0;
            opc   <= '0;
            armed <= 1'b0;
        end else begin
            if (sel && capture_en)
                sr <= {inst_done, {DW{1'b0}}};
            else if (sel && shift_en)
                sr <= {tdi, sr[LEN-1:1]};
            if (issue_req && st == ITR_IDLE)
                armed <= 1'b0;
            if (sel && update_en && st == ITR_IDLE) begin
                opc   <= sr[DW-1:0];
                armed <= 1'b1;
            end
        end
    end

    assign tdo_bit = sr[0];
    assign op_data = opc;
endmodule

// File: rtl/dbg_dtr_chain.sv
module dbg_dtr_chain #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          dir_ext,
    input  logic          tdi,
    input  logic          capture_en,
    input  logic          shift_en,
    input  logic          update_en,
    output logic          tdo_bit,
    output logic [DW-1:0] wdtr_data,
    output logic          wdtr_full,
    input  logic          wdtr_rd,
    input  logic          rdtr_wr,
    input  logic [DW-1:0] rdtr_wdata,
    output logic          rdtr_full
);
    localparam int LEN = DW + 2;

    logic [LEN-1:0] sr;
    logic           cap_rdy;
    logic [DW-1:0]  in_q;
    logic           out_put;
    logic           in_take;

    assign out_put = sel && dir_ext && update_en && cap_rdy;
    assign in_take = sel && !dir_ext && capture_en;

    dbg_mbox #(.DW(DW)) u_out (
        .clk(clk), .rst_n(rst_n), .put(out_put), .put_data(sr[DW-1:0]),
        .take(wdtr_rd), .full(wdtr_full), .q(wdtr_data)
    );

    dbg_mbox #(.DW(DW)) u_in (
        .clk(clk), .rst_n(rst_n), .put(rdtr_wr), .put_data(rdtr_wdata),
        .take(in_take), .full(rdtr_full), .q(in_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr      <= '0;
            cap_rdy <= 1'b0;
        end else if (sel && capture_en) begin
            if (dir_ext) begin
                sr      <= {1'b0, !wdtr_full, {DW{1'b0}}};
                cap_rdy <= !wdtr_full;
            end else begin
                sr      <= {1'b0, rdtr_full, rdtr_full ? in_q : {DW{1'b0}}};
                cap_rdy <= 1'b0;
            end
        end else if (sel && shift_en) begin
            sr <= {tdi, sr[LEN-1:1]};
        end
    end

    assign tdo_bit = sr[0];
endmodule

// File: rtl/dbg_xfer_chains.sv
module dbg_xfer_chains
    import dbg_xfer_pkg::*;
#(
    parameter int DW = DEF_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tdi,
    input  logic          capture_en,
    input  logic          shift_en,
    input  logic          update_en,
    input  logic          idle_enter,
    input  logic          sel_itr,
    input  logic          sel_dtr,
    input  logic          dir_ext,
    output logic          tdo,
    output logic          op_valid,
    output logic [DW-1:0] op_data,
    input  logic          op_accept,
    input  logic          op_done,
    output logic [DW-1:0] wdtr_data,
    output logic          wdtr_full,
    input  logic          wdtr_rd,
    input  logic          rdtr_wr,
    input  logic [DW-1:0] rdtr_wdata,
    output logic          rdtr_full
);
    logic itr_tdo;
    logic dtr_tdo;

    dbg_itr_chain #(.DW(DW)) u_itr (
        .clk(clk), .rst_n(rst_n), .sel(sel_itr), .reissue_sel(sel_dtr),
        .tdi(tdi), .capture_en(capture_en), .shift_en(shift_en),
        .update_en(update_en), .idle_enter(idle_enter), .tdo_bit(itr_tdo),
        .op_valid(op_valid), .op_data(op_data), .op_accept(op_accept),
        .op_done(op_done)
    );

    dbg_dtr_chain #(.DW(DW)) u_dtr (
        .clk(clk), .rst_n(rst_n), .sel(sel_dtr), .dir_ext(dir_ext),
        .tdi(tdi), .capture_en(capture_en), .shift_en(shift_en),
        .update_en(update_en), .tdo_bit(dtr_tdo), .wdtr_data(wdtr_data),
        .wdtr_full(wdtr_full), .wdtr_rd(wdtr_rd), .rdtr_wr(rdtr_wr),
        .rdtr_wdata(rdtr_wdata), .rdtr_full(rdtr_full)
    );

    assign tdo = sel_itr ? itr_tdo : (sel_dtr ? dtr_tdo : 1'b0);
endmodule

// File: rtl/dbg_xfer_chains_chk.sv
module dbg_xfer_chains_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          capture_en,
    input logic          update_en,
    input logic          idle_enter,
    input logic          sel_dtr,
    input logic          dir_ext,
    input logic          op_valid,
    input logic [DW-1:0] op_data,
    input logic          op_accept,
    input logic [DW-1:0] wdtr_data,
    input logic          wdtr_full,
    input logic          wdtr_rd,
    input logic          rdtr_full
);
    logic in_cap;
    assign in_cap = capture_en && sel_dtr && !dir_ext;

    a_r3_issue_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(op_valid) |-> $past(idle_enter));

    a_r6_offer_held: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && !op_accept |=> op_valid && $stable(op_data));

    a_r8_full_from_update: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdtr_full) |-> $past(update_en && sel_dtr && dir_ext));

    a_r9_out_word_kept: assert property (@(posedge clk) disable iff (!rst_n)
        wdtr_full && !wdtr_rd |=> wdtr_full && $stable(wdtr_data));

    a_r10_in_cleared_by_capture: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdtr_full) |-> $past(in_cap));

    a_r11_in_stays_full: assert property (@(posedge clk) disable iff (!rst_n)
        rdtr_full && !in_cap |=> rdtr_full);
endmodule

bind dbg_xfer_chains dbg_xfer_chains_chk #(.DW(DW)) u_chk (.*);

// File: tb/tb_dbg_xfer_chains.sv
module tb_dbg_xfer_chains;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tdi = 0, capture_en = 0, shift_en = 0, update_en = 0, idle_enter = 0;
    logic sel_itr = 0, sel_dtr = 0, dir_ext = 0;
    logic tdo, op_valid, op_accept = 0, op_done = 0;
    logic [DW-1:0] op_data, wdtr_data, rdtr_wdata = '0;
    logic wdtr_full, wdtr_rd = 0, rdtr_wr = 0, rdtr_full;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    dbg_xfer_chains #(.DW(DW)) dut (.*);

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [33:0] exp_dtr(input bit ext, input bit full, input logic [31:0] w);
        if (ext) return {1'b0, !full, 32'h0};
        return {1'b0, full, full ? w : 32'h0};
    endfunction

    task automatic scan(input bit itr, input bit ext, input logic [33:0] din,
                        input bit go_idle, output logic [33:0] dout);
        int n;
        n = itr ? 33 : 34;
        dout = '0;
        @(negedge clk);
        sel_itr = itr; sel_dtr = !itr; dir_ext = ext; capture_en = 1;
        @(negedge clk);
        capture_en = 0;
        for (int i = 0; i < n; i++) begin
            shift_en = 1; tdi = din[i];
            dout[i] = tdo;
            @(negedge clk);
        end
        shift_en = 0; update_en = 1;
        @(negedge clk);
        update_en = 0;
        if (go_idle) begin
            idle_enter = 1;
            @(negedge clk);
            idle_enter = 0;
        end
    endtask

    task automatic pulse_accept(); op_accept = 1; @(negedge clk); op_accept = 0; endtask
    task automatic pulse_done();   op_done = 1;   @(negedge clk); op_done = 0;   endtask
    task automatic pulse_rd();     wdtr_rd = 1;   @(negedge clk); wdtr_rd = 0;   endtask
    task automatic core_write(input logic [31:0] w);
        rdtr_wdata = w; rdtr_wr = 1; @(negedge clk); rdtr_wr = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [33:0] o;
        logic [31:0] opA, opC, w0, w1, v0, v1;
        int unsigned seed;
        seed = $urandom(32'd2024);
        opA = 32'hE1A0_0001; opC = 32'h1234_5678;
        w0 = 32'hCAFE_0001; w1 = 32'h5555_AAAA;
        v0 = 32'h0BAD_F00D; v1 = 32'hFFFF_0000;

        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(op_valid == 0 && wdtr_full == 0 && rdtr_full == 0, "R1 reset flags",
            {op_valid, wdtr_full, rdtr_full}, 0);

        // R1/R2 status bit after reset; R4 load without issue
        scan(1, 0, {2'b0, opA}, 0, o);
        chk(o[32] == 1, "R1 R2 completion bit after reset", o[32], 1);
        chk(op_valid == 0, "R4 pause-end does not issue", op_valid, 0);

        // R4/R12 issue via data chain; R7/R8 EXTEST write
        scan(0, 1, {2'b0, w0}, 1, o);
        chk(o == exp_dtr(1, 0, 0), "R7 R8 extest capture empty", o, exp_dtr(1, 0, 0));
        chk(op_valid == 1 && op_data == opA, "R4 R12 issue from data chain",
            {op_valid, op_data}, {1'b1, opA});
        chk(wdtr_full == 1 && wdtr_data == w0, "R8 outbound stored",
            {wdtr_full, wdtr_data}, {1'b1, w0});

        // R5/R6/R13 while offered
        scan(1, 0, {2'b0, opC}, 1, o);
        chk(o[32] == 0, "R5 completion 0 while offered", o[32], 0);
        chk(op_valid == 1 && op_data == opA, "R6 R13 update and issue ignored",
            {op_valid, op_data}, {1'b1, opA});
        pulse_accept();
        chk(op_valid == 0, "R6 offer dropped on accept", op_valid, 0);
        scan(1, 0, 34'h0, 0, o);
        chk(o[32] == 0, "R5 completion 0 while executing", o[32], 0);
        pulse_done();
        scan(1, 0, 34'h0, 0, o);
        chk(o[32] == 1, "R5 completion 1 after done", o[32], 1);

        // R9 write to full outbound
        scan(0, 1, {2'b0, w1}, 0, o);
        chk(o[32] == 0 && o[33] == 0, "R9 R7 ready 0 when full", o[33:32], 0);
        chk(wdtr_data == w0, "R9 word ignored", wdtr_data, w0);
        pulse_rd();
        chk(wdtr_full == 0, "R8 read clears full", wdtr_full, 0);
        scan(0, 1, {2'b0, w1}, 0, o);
        chk(o[32] == 1 && wdtr_data == w1, "R8 rescan accepted", {o[32], wdtr_data}, {1'b1, w1});
        pulse_rd();

        // R10/R11 inbound
        scan(0, 0, 34'h0, 0, o);
        chk(o == exp_dtr(0, 0, 0), "R10 intest empty", o, exp_dtr(0, 0, 0));
        core_write(v0);
        chk(rdtr_full == 1, "R10 inbound set", rdtr_full, 1);
        core_write(v1);
        scan(0, 0, 34'h0, 0, o);
        chk(o == exp_dtr(0, 1, v0), "R11 R10 intest returns first word", o, exp_dtr(0, 1, v0));
        chk(rdtr_full == 0, "R10 capture clears full", rdtr_full, 0);

        // R3 direct issue
        scan(1, 0, {2'b0, opC}, 1, o);
        chk(op_valid == 1 && op_data == opC, "R3 direct issue", {op_valid, op_data}, {1'b1, opC});
        pulse_accept(); pulse_done();

        // R12 burst re-issue
        for (int k = 0; k < 3; k++) begin
            scan(0, 0, 34'h0, 1, o);
            chk(op_valid == 1 && op_data == opC, "R12 burst re-issue",
                {op_valid, op_data}, {1'b1, opC});
            pulse_accept(); pulse_done();
        end

        // random mix
        for (int it = 0; it < 20; it++) begin
            logic [31:0] r_op, r_w, r_v;
            r_op = $urandom; r_w = $urandom; r_v = $urandom;
            scan(1, 0, {2'b0, r_op}, 1, o);
            chk(o[32] == 1, "R2 random status", o[32], 1);
            chk(op_valid == 1 && op_data == r_op, "R3 random issue",
                {op_valid, op_data}, {1'b1, r_op});
            repeat ($urandom_range(0, 3)) @(negedge clk);
            pulse_accept();
            repeat ($urandom_range(0, 3)) @(negedge clk);
            pulse_done();
            scan(0, 1, {2'b0, r_w}, 0, o);
            chk(o == exp_dtr(1, 0, 0) && wdtr_data == r_w, "R8 random outbound",
                {o, wdtr_data}, {exp_dtr(1, 0, 0), r_w});
            pulse_rd();
            core_write(r_v);
            scan(0, 0, 34'h0, 0, o);
            chk(o == exp_dtr(0, 1, r_v), "R10 random inbound", o, exp_dtr(0, 1, r_v));
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule